// File: doc/BRIEF.md
# Overlap-Safe Byte Block Copy Engine

This engine copies a run of bytes from one place in a memory to another place in the same memory. A single start pulse delivers a source byte address, a destination byte address and a byte count. The engine then steps through the run with a series of reads and writes on a word-wide memory port that uses byte enables. It pulses `done` when the last write has been accepted. The memory contents it leaves behind are always the same as those of a plain loop that copies one byte at a time, in rising address order. This holds when the two ranges overlap. In particular, a destination one byte above the source smears the first source byte across the whole destination.

To go faster, the engine chooses a wide mode at start time when the mode is safe. In wide mode each read and write moves every byte of the current word that lies inside the run. Wide mode needs two things: the source and destination must have the same offset within a word, and the destination must not begin inside the part of the source that has not yet been read. In every other case the engine moves one byte per read/write pair.

Before it touches memory, the engine compares the word of an earlier store that is still outstanding against both of its ranges. If that word overlaps either range, the engine waits until the store is gone.

Top module: `byte_mover`

## Requirements
- R1: After `done`, memory equals the result of copying `len` bytes one at a time, from index 0 upward, `mem[dst+i] = mem[src+i]`, for any source and destination that do not overlap.
- R2: Overlapping ranges give the same byte-serial result. In particular, when `dstAddr == srcAddr + 1`, every destination byte ends equal to the original byte at `srcAddr`.
- R3: Wide mode is chosen when `srcAddr % WORD_BYTES == dstAddr % WORD_BYTES` and either `dstAddr <= srcAddr` or `dstAddr >= srcAddr + len`. In wide mode the number of writes equals the number of destination words the run touches. In byte mode the number of writes equals `len`.
- R4: Every copy step is exactly one read (`memWe`=0) followed by one write (`memWe`=1), so the read count equals the write count. Writes set `memBe` bit k only for lane k, the byte at word address + k, and only where that byte lies in the destination range. No byte outside the destination range changes.
- R5: The outstanding store covers the word that holds `pendAddr`. While `pendValid` is high and that word overlaps `[srcAddr, srcAddr+len)` or `[dstAddr, dstAddr+len)`, the engine issues no memory request and stays busy. A store word that overlaps neither range causes no wait.
- R6: A start with `len == 0` makes no memory access, leaves `busy` low, and raises `done` in the cycle after the start edge.
- R7: `busy` is high from the cycle after an accepted nonzero start. `done` is high for exactly one cycle, the cycle after the edge that accepted the last write, and `busy` is low in that cycle.
- R8: A start while `busy` is high is ignored. The copy in progress completes unchanged, and the ignored command causes no access.
- R9: A request (`memReq` high) that sees `memRdy` low is held in the next cycle with the same address, write flag, enables and data.
- R10: During and after reset, `busy`, `done` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, taken when idle |
| srcAddr | input | ADDR_W | First source byte address |
| dstAddr | input | ADDR_W | First destination byte address |
| len | input | LEN_W | Byte count |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| pendValid | input | 1 | An earlier store is still outstanding |
| pendAddr | input | ADDR_W | Byte address inside the outstanding store's word |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Word-aligned byte address |
| memBe | output | WORD_BYTES | Byte-lane enables |
| memWdata | output | 8*WORD_BYTES | Write data, lane k in bits 8k+7..8k |
| memRdata | input | 8*WORD_BYTES | Read data, valid while memRdy is high |
| memRdy | input | 1 | Request accepted this cycle |

## Verification
A wrong mode choice shows up as a changed write count when `done` arrives. If it picks wide mode where it must not, corrupted destination bytes also appear right after the copy of an overlapping run, most visibly in the one-byte fill case. A stepping or lane-enable error puts a wrong byte, or a changed byte just outside the destination, into memory on the first affected write. A wrong conflict decision shows within a cycle as a request during a stall, or as a copy that starts late. A slip in the sequencer shows as a missing, early or doubled `done` pulse, or as a start that is taken while busy.

// File: rtl/bm_pkg.sv
`timescale 1ns/1ps
package bm_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic load;     // capture a new command
    logic capture;  // latch read data
    logic advance;  // step pointers past the current chunk
  } dpCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic conflict;   // outstanding store overlaps a range
    logic lastChunk;  // current chunk finishes the run
  } dpStat_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } mvState_t;
endpackage

// File: rtl/bm_datapath.sv
`timescale 1ns/1ps
module bm_datapath
  import bm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [ADDR_W-1:0]       cmdSrc,
  input  logic [ADDR_W-1:0]       cmdDst,
  input  logic [LEN_W-1:0]        cmdLen,
  input  logic                    pendValid,
  input  logic [ADDR_W-1:0]       pendAddr,
  input  logic [8*WORD_BYTES-1:0] memRdata,
  output dpStat_t                 stat,
  output logic [ADDR_W-1:0]       rdAddr,
  output logic [ADDR_W-1:0]       wrAddr,
  output logic [8*WORD_BYTES-1:0] wrData,
  output logic [WORD_BYTES-1:0]   wrBe
);
  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam int CNT_W  = OFF_W + 1;
  localparam int DATA_W = 8 * WORD_BYTES;
  localparam int SUM_W  = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  logic [ADDR_W-1:0] curSrc, curDst;
  logic [LEN_W-1:0]  remain;
  logic              wideMode;
  logic [DATA_W-1:0] holdWord;

  // ---- mode choice from the incoming command ----
  logic [SUM_W-1:0] cmdSrcEnd;
  logic             cmdWide;
  always_comb begin
    cmdSrcEnd = SUM_W'(cmdSrc) + SUM_W'(cmdLen);
    cmdWide   = (cmdSrc[OFF_W-1:0] == cmdDst[OFF_W-1:0]) &&
                ((cmdDst <= cmdSrc) || (SUM_W'(cmdDst) >= cmdSrcEnd));
  end

  // ---- chunk size ----
  logic [OFF_W-1:0] srcOff, dstOff;
  logic [CNT_W-1:0] room, chunk;
  always_comb begin
    srcOff = curSrc[OFF_W-1:0];
    dstOff = curDst[OFF_W-1:0];
    room   = CNT_W'(WORD_BYTES) - {1'b0, srcOff};
    if (!wideMode)
      chunk = CNT_W'(1);
    else if (SUM_W'(remain) < SUM_W'(room))
      chunk = CNT_W'(remain);
    else
      chunk = room;
    stat.lastChunk = SUM_W'(remain) <= SUM_W'(chunk);
  end

  // ---- range check against the outstanding store word ----
  logic [SUM_W-1:0] pendWord, srcEnd, dstEnd;
  logic             hitSrc, hitDst;
  always_comb begin
    pendWord = SUM_W'(pendAddr) & ~SUM_W'(WORD_BYTES - 1);
    srcEnd   = SUM_W'(curSrc) + SUM_W'(remain);
    dstEnd   = SUM_W'(curDst) + SUM_W'(remain);
    hitSrc   = (pendWord < srcEnd) &&
               (pendWord + SUM_W'(WORD_BYTES) > SUM_W'(curSrc));
    hitDst   = (pendWord < dstEnd) &&
               (pendWord + SUM_W'(WORD_BYTES) > SUM_W'(curDst));
    stat.conflict = pendValid && (hitSrc || hitDst);
  end

  // ---- registers ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrc   <= '0;
      curDst   <= '0;
      remain   <= '0;
      wideMode <= 1'b0;
      holdWord <= '0;
    end else begin
      if (ctl.load) begin
        curSrc   <= cmdSrc;
        curDst   <= cmdDst;
        remain   <= cmdLen;
        wideMode <= cmdWide;
      end
      if (ctl.capture)
        holdWord <= memRdata;
      if (ctl.advance) begin
        curSrc <= curSrc + ADDR_W'(chunk);
        curDst <= curDst + ADDR_W'(chunk);
        remain <= remain - LEN_W'(chunk);
      end
    end
  end

  // ---- addresses, lane enables, data ----
  logic [7:0]        selByte;
  logic [DATA_W-1:0] byteRep;
  logic [WORD_BYTES-1:0] wideHit;

  assign rdAddr  = {curSrc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wrAddr  = {curDst[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign selByte = holdWord[{srcOff, 3'b000} +: 8];

  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
    localparam logic [CNT_W-1:0] LANE = CNT_W'(l);
    assign wideHit[l]         = (LANE >= {1'b0, srcOff}) &&
                                (LANE < ({1'b0, srcOff} + chunk));
    assign wrBe[l]            = wideMode ? wideHit[l] : (dstOff == OFF_W'(l));
    assign byteRep[8*l +: 8]  = selByte;
  end

  assign wrData = wideMode ? holdWord : byteRep;

  // ---- assertions ----
  // R3: byte mode moves exactly one byte per write
  a_r3_byte_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !wideMode) |-> ($countones(wrBe) == 1));
  // R3: wide mode only runs with matching word offsets
  a_r3_wide_same_offset: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && wideMode) |-> (curSrc[OFF_W-1:0] == curDst[OFF_W-1:0]));
  // R4: every write enables at least one lane
  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (wrBe != '0));
  // R4: no chunk runs past the bytes still to move
  a_r4_chunk_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> (SUM_W'(chunk) <= SUM_W'(remain)));
endmodule

// File: rtl/bm_control.sv
`timescale 1ns/1ps
module bm_control
  import bm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cmdLenZero,
  input  dpStat_t stat,
  input  logic    memRdy,
  output dpCtl_t  ctl,
  output logic    memReq,
  output logic    memWe,
  output logic    busy,
  output logic    done
);
  mvState_t state, stateNxt;
  logic     doneNxt;

  always_comb begin
    ctl      = '0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    stateNxt = state;
    doneNxt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (cmdLenZero) doneNxt = 1'b1;
          else begin
            ctl.load = 1'b1;
            stateNxt = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!stat.conflict) stateNxt = ST_READ;
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memRdy) begin
          ctl.capture = 1'b1;
          stateNxt    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memRdy) begin
          ctl.advance = 1'b1;
          if (stat.lastChunk) begin
            stateNxt = ST_IDLE;
            doneNxt  = 1'b1;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
    end
  end

  assign busy = (state != ST_IDLE);

  // R7: the completion pulse never overlaps a busy cycle
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R5: a conflicting store keeps the port quiet in the next cycle
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && stat.conflict) |=> !memReq);
  // R6: zero-length command completes at once with no access
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && cmdLenZero) |=> (done && !memReq && !busy));
  // R8: a start while busy does not restart the sequence
  a_r8_busy_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !ctl.load);
endmodule

// File: rtl/byte_mover.sv
`timescale 1ns/1ps
module byte_mover
  import bm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       srcAddr,
  input  logic [ADDR_W-1:0]       dstAddr,
  input  logic [LEN_W-1:0]        len,
  output logic                    busy,
  output logic                    done,
  input  logic                    pendValid,
  input  logic [ADDR_W-1:0]       pendAddr,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORD_BYTES-1:0]   memBe,
  output logic [8*WORD_BYTES-1:0] memWdata,
  input  logic [8*WORD_BYTES-1:0] memRdata,
  input  logic                    memRdy
);
  dpCtl_t  ctl;
  dpStat_t stat;
  logic [ADDR_W-1:0]       rdAddr, wrAddr;
  logic [WORD_BYTES-1:0]   wrBe;

  bm_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cmdLenZero (len == '0),
    .stat       (stat),
    .memRdy     (memRdy),
    .ctl        (ctl),
    .memReq     (memReq),
    .memWe      (memWe),
    .busy       (busy),
    .done       (done)
  );

  bm_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cmdSrc    (srcAddr),
    .cmdDst    (dstAddr),
    .cmdLen    (len),
    .pendValid (pendValid),
    .pendAddr  (pendAddr),
    .memRdata  (memRdata),
    .stat      (stat),
    .rdAddr    (rdAddr),
    .wrAddr    (wrAddr),
    .wrData    (memWdata),
    .wrBe      (wrBe)
  );

  assign memAddr = memWe ? wrAddr : rdAddr;
  assign memBe   = memWe ? wrBe : '1;

  // R9: a stalled request is held unchanged
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> (memReq && $stable(memAddr) && $stable(memWe) &&
                             $stable(memBe) && $stable(memWdata)));
  // R4: reads always use every lane
  a_r4_read_full: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memBe == '1));
  // R10: the port is quiet whenever the engine is idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);
endmodule

// File: tb/byte_mover_tb.sv
`timescale 1ns/1ps
module byte_mover_tb;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam int WB = 4;
  localparam int DW = 8 * WB;
  localparam int NVEC = 11;

  // {src, dst, len, expected writes}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h10, 8'h40, 8'd16, 8'd4},   // aligned, disjoint: wide
    {8'h11, 8'h41, 8'd10, 8'd3},   // same offset 1: wide, partial ends
    {8'h12, 8'h41, 8'd7,  8'd7},   // offsets differ: bytes
    {8'h20, 8'h21, 8'd12, 8'd12},  // dst = src+1: fill
    {8'h30, 8'h2E, 8'd9,  8'd9},   // offsets differ, dst below
    {8'h34, 8'h30, 8'd12, 8'd3},   // overlap, dst below, same offset: wide
    {8'h50, 8'h52, 8'd5,  8'd5},   // overlap upward, offsets differ
    {8'h63, 8'h73, 8'd3,  8'd2},   // offset 3: two partial words
    {8'h80, 8'h80, 8'd8,  8'd2},   // dst == src
    {8'h90, 8'h94, 8'd12, 8'd12},  // same offset but dst inside src: bytes
    {8'hA0, 8'hC0, 8'd32, 8'd8}    // longer wide run
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] srcAddr = '0, dstAddr = '0, pendAddr = '0;
  logic [LW-1:0] len = '0;
  logic          pendValid = 1'b0;
  logic          busy, done, memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [WB-1:0] memBe;
  logic [DW-1:0] memWdata, memRdata;
  logic          memRdy;

  byte_mover #(.ADDR_W(AW), .LEN_W(LW), .WORD_BYTES(WB)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .len(len), .busy(busy), .done(done), .pendValid(pendValid), .pendAddr(pendAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .memRdy(memRdy)
  );

  // ---- memory model ----
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  int rdCnt = 0, wrCnt = 0, reqCyc = 0, heldErr = 0, cyc = 0;
  logic prevStall = 1'b0, prevWe = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  logic stallOn = 1'b0;
  int   sc = 0;
  int   checks = 0, errors = 0;

  always_comb
    for (int k = 0; k < WB; k++)
      memRdata[8*k +: 8] = mem[8'(memAddr[7:0] + 8'(k))];

  always @(negedge clk) begin
    sc     <= sc + 1;
    memRdy <= !(stallOn && (sc % 3 == 1));
  end

  always @(posedge clk) begin
    if (memReq) reqCyc <= reqCyc + 1;
    if (prevStall && (!memReq || memAddr != prevAddr || memWe != prevWe))
      heldErr <= heldErr + 1;
    prevStall <= memReq && !memRdy;
    prevAddr  <= memAddr;
    prevWe    <= memWe;
    if (memReq && memRdy) begin
      if (memWe) begin
        wrCnt <= wrCnt + 1;
        for (int k = 0; k < WB; k++)
          if (memBe[k]) mem[8'(memAddr[7:0] + 8'(k))] <= memWdata[8*k +: 8];
      end else begin
        rdCnt <= rdCnt + 1;
      end
    end
  end

  // ---- watchdog ----
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act %0d exp <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---- helpers ----
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 13 + seed);
      expMem[i] = mem[i];
    end
  endtask

  task automatic modelCopy(input logic [7:0] s, input logic [7:0] d, input int l);
    for (int i = 0; i < l; i++) expMem[8'(d + 8'(i))] = expMem[8'(s + 8'(i))];
  endtask

  function automatic int mismatches();
    int m = 0;
    for (int i = 0; i < 256; i++) if (mem[i] != expMem[i]) m++;
    return m;
  endfunction

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic [7:0] s, input logic [7:0] d, input int l);
    start   = 1'b1;
    srcAddr = AW'(s);
    dstAddr = AW'(d);
    len     = LW'(l);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit ok, output int n);
    n  = 0;
    ok = 1'b1;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 4000) begin ok = 1'b0; break; end
    end
  endtask

  initial begin
    bit ok;
    int n, r0, w0, q0, mm;
    logic [7:0] s, d, l, ew, first;

    // R10: reset state
    fillMem(0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReq, "R10 reset outputs", {busy, done, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReq, "R10 after reset", {busy, done, memReq}, 0);

    // ---- table walk: R1 R2 R3 R4 R7 R9 ----
    for (int v = 0; v < NVEC; v++) begin
      {s, d, l, ew} = VEC[v];
      stallOn = (v % 2 == 1);
      fillMem(v * 5 + 1);
      first = mem[s];
      modelCopy(s, d, int'(l));
      r0 = rdCnt;
      w0 = wrCnt;
      issue(s, d, int'(l));
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      waitDone(ok, n);
      chk(ok, "R7 done arrives", n, 0);
      chk(!busy, "R7 idle during done", busy, 0);
      mm = mismatches();
      if (d > s && d < s + l) chk(mm == 0, "R2 overlap byte-serial result", mm, 0);
      else                    chk(mm == 0, "R1 copy result", mm, 0);
      chk(wrCnt - w0 == int'(ew), "R3 write count", wrCnt - w0, int'(ew));
      chk(rdCnt - r0 == wrCnt - w0, "R4 reads match writes", rdCnt - r0, wrCnt - w0);
      if (d == s + 1)
        for (int i = 0; i < int'(l); i++)
          chk(mem[8'(d + 8'(i))] == first, "R2 fill replicates first byte",
              mem[8'(d + 8'(i))], first);
      @(negedge clk);
      chk(!done, "R7 single-cycle done", done, 0);
    end
    stallOn = 1'b0;
    chk(heldErr == 0, "R9 stalled request held", heldErr, 0);

    // ---- R6: zero length ----
    repeat (2) @(negedge clk);
    q0 = reqCyc;
    issue(8'h10, 8'h40, 0);
    chk(done == 1'b1, "R6 done after zero-length start", done, 1);
    chk(!busy, "R6 busy stays low", busy, 0);
    @(negedge clk);
    chk(!done, "R6 done one cycle", done, 0);
    chk(reqCyc == q0, "R6 no memory access", reqCyc - q0, 0);

    // ---- R5: conflict on destination word ----
    fillMem(77);
    modelCopy(8'h10, 8'h40, 8);
    pendValid = 1'b1;
    pendAddr  = AW'(16'h0043);
    q0 = reqCyc;
    issue(8'h10, 8'h40, 8);
    repeat (30) @(negedge clk);
    chk(reqCyc == q0, "R5 dst conflict blocks requests", reqCyc - q0, 0);
    chk(busy == 1'b1, "R5 busy while waiting", busy, 1);
    pendValid = 1'b0;
    waitDone(ok, n);
    mm = mismatches();
    chk(ok && mm == 0, "R5 copy after release", mm, 0);
    @(negedge clk);

    // R5: conflict on source word
    fillMem(33);
    modelCopy(8'h10, 8'h40, 8);
    pendValid = 1'b1;
    pendAddr  = AW'(16'h0015);
    q0 = reqCyc;
    issue(8'h10, 8'h40, 8);
    repeat (10) @(negedge clk);
    chk(reqCyc == q0, "R5 src conflict blocks requests", reqCyc - q0, 0);
    pendValid = 1'b0;
    waitDone(ok, n);
    mm = mismatches();
    chk(ok && mm == 0, "R5 src conflict copy", mm, 0);
    @(negedge clk);

    // R5: disjoint store word does not delay
    fillMem(44);
    modelCopy(8'h10, 8'h40, 8);
    pendValid = 1'b1;
    pendAddr  = AW'(16'h00C1);
    issue(8'h10, 8'h40, 8);
    waitDone(ok, n);
    chk(ok && n < 12, "R5 no wait without overlap", n, 11);
    mm = mismatches();
    chk(mm == 0, "R5 disjoint store copy", mm, 0);
    pendValid = 1'b0;
    @(negedge clk);

    // ---- R8: start while busy ----
    fillMem(91);
    modelCopy(8'h10, 8'h40, 16);
    w0 = wrCnt;
    issue(8'h10, 8'h40, 16);
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy before second start", busy, 1);
    issue(8'h10, 8'h80, 8);
    waitDone(ok, n);
    @(negedge clk);
    repeat (20) @(negedge clk);
    mm = mismatches();
    chk(ok && mm == 0, "R8 second start ignored (memory)", mm, 0);
    chk(wrCnt - w0 == 4, "R8 only first command's writes", wrCnt - w0, 4);
    chk(!busy && !done, "R8 engine idle afterwards", {busy, done}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule